// File: doc/BRIEF.md
# Multi-Input Wake-Up Edge Monitor

This block watches a small group of digitally sampled monitor pins. Each pin is cleaned by its own deglitch filter, clocked by a slow tick. While the system runs, the block reports the filtered level of every enabled pin in a status word that an SPI slave shifts out. While the system is in a low-power mode, the block compares every enabled and settled pin against a reference level. That reference is taken in the last cycle before low-power entry. A change in either direction raises a wake-up request toward the host.

The wake-up request is a level. It stays high until the host reads the status word once. That first read returns the flags of the channels that caused the wake-up. Every later read returns the live filtered levels again. A freshly enabled channel is kept out of wake-up detection for a programmable number of clock cycles, so that a pin that is still settling does not wake the system.

The controller has three states:
- `ST_AWAKE` (running, reference tracks the filtered levels).
- `ST_DOZE` (low power, references frozen).
- `ST_ALERT` (wake pending, source flags shown).

It has four transitions:
- AWAKE→DOZE when the mode becomes sleep or stop.
- DOZE→AWAKE when the mode returns to active or standby with no event.
- DOZE→ALERT when an armed channel differs from its reference.
- ALERT→AWAKE on a status read.

Top module: `wake_monitor_top`

## Requirements
- R1: After reset, `wake_req` is 0 and `stat_word` is all zeros.
- R2: In active (`mode_sel`=00) or standby (01) mode, with no wake pending, bit i of `stat_word` equals the filtered level of enabled channel i.
- R3: A disabled channel (`chan_en` bit 0) reads as 0 in `stat_word` and never causes a wake-up.
- R4: A pin change is accepted into the filtered level only after the pin has differed from it on `filt_len` consecutive ticks. A change that reverts sooner leaves the level unchanged.
- R5: A `filt_len` of 0 behaves as 1, so one tick accepts a change.
- R6: In sleep (`mode_sel`=10) or stop (11) mode, a rising or a falling filtered edge on an armed channel raises `wake_req`. Changes in active or standby mode never raise it.
- R7: Once raised, `wake_req` stays high until a `stat_rd` pulse, whatever the pins and mode do.
- R8: While `wake_req` is high, `stat_word` shows the wake source flags. A `stat_rd` pulse clears the flags and `wake_req`, and from then on `stat_word` shows live levels.
- R9: The reference of each channel is its filtered level in the last cycle before low-power entry. A pin that was already high at entry does not wake the system.
- R10: All channels that differ from their references in the detection cycle are flagged as sources.
- R11: A channel enabled less than `SETTLE_CYC` cycles ago is ignored for wake-up. A change during that window is absorbed into its reference.
- R12: Leaving low power without an event leaves `wake_req` at 0, and the next status word shows live levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow filter tick, one clock wide |
| pin_in | input | NCH | Synchronized monitor pins |
| chan_en | input | NCH | Per-channel enable |
| mode_sel | input | 2 | 00 active, 01 standby, 10 sleep, 11 stop |
| filt_len | input | FILT_W | Filter length in ticks |
| stat_rd | input | 1 | Status-word read strobe, one clock wide |
| wake_req | output | 1 | Wake-up request level to host |
| stat_word | output | NCH | Live levels, or wake source flags while a wake is pending |

## Verification
The bench aims at the cases where a sloppy design wakes wrongly or reports wrongly:

- **Pin high at entry:** a design that compares against a fixed zero instead of the captured reference would wake at once when a pin is already high as low power begins.
- **Fresh enable:** a design without the settle guard would wake on a channel that toggles right after being enabled.
- **Simultaneous changes:** one that records only the lowest changed channel would miss a second source on the same tick.
- **Source read:** the read sequence checks that the flags appear exactly once. A design that never switches back would keep showing flags, and one that ignored the read would hold `wake_req` high forever.

// File: rtl/wkm_pkg.sv
package wkm_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'b00,
        MODE_STANDBY = 2'b01,
        MODE_SLEEP   = 2'b10,
        MODE_STOP    = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_DOZE  = 2'd1,
        ST_ALERT = 2'd2
    } wstate_e;

    function automatic logic is_low_power(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/wkm_deglitch.sv
module wkm_deglitch #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             raw,
    input  logic [LEN_W-1:0] len,
    output logic             lvl
);
    logic [LEN_W-1:0] run_cnt;
    logic [LEN_W-1:0] last_idx;

    // a zero length is treated as a single tick
    always_comb begin
        if (len == '0) last_idx = '0;
        else           last_idx = len - LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl     <= 1'b0;
            run_cnt <= '0;
        end else if (tick) begin
            if (raw != lvl) begin
                if (run_cnt >= last_idx) begin
                    lvl     <= raw;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + LEN_W'(1);
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/wkm_settle.sv
module wkm_settle #(
    parameter int DELAY = 12,
    localparam int W = (DELAY < 1) ? 1 : $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic armed
);
    logic [W-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= W'(DELAY);
        end else if (!en) begin
            wait_cnt <= W'(DELAY);
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - W'(1);
        end
    end

    assign armed = en && (wait_cnt == '0);
endmodule

// File: rtl/wkm_ctrl.sv
module wkm_ctrl
    import wkm_pkg::*;
#(
    parameter int NCH = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     mode_sel,
    input  logic [NCH-1:0] filt_lvl,
    input  logic [NCH-1:0] armed_mask,
    input  logic [NCH-1:0] chan_en,
    input  logic           stat_rd,
    output logic           wake_req,
    output logic [NCH-1:0] stat_word
);
    wstate_e        st_q, st_d;
    logic [NCH-1:0] ref_q;
    logic [NCH-1:0] src_q;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] hold_ref;

    assign hit = armed_mask & (filt_lvl ^ ref_q);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_AWAKE: if (is_low_power(mode_sel)) st_d = ST_DOZE;
            ST_DOZE: begin
                if (!is_low_power(mode_sel)) st_d = ST_AWAKE;
                else if (|hit)               st_d = ST_ALERT;
            end
            ST_ALERT: if (stat_rd) st_d = ST_AWAKE;
            default:  st_d = ST_AWAKE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_AWAKE;
        else        st_q <= st_d;
    end

    // references freeze only for armed channels outside the running state
    assign hold_ref = (st_q == ST_AWAKE) ? '0 : armed_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= '0;
            src_q <= '0;
        end else begin
            ref_q <= (ref_q & hold_ref) | (filt_lvl & ~hold_ref);
            if (st_q == ST_DOZE && st_d == ST_ALERT) src_q <= hit;
            else if (st_q == ST_ALERT && stat_rd)    src_q <= '0;
        end
    end

    // outputs
    always_comb begin
        wake_req  = 1'b0;
        stat_word = filt_lvl & chan_en;
        unique case (st_q)
            ST_ALERT: begin
                wake_req  = 1'b1;
                stat_word = src_q;
            end
            ST_AWAKE, ST_DOZE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/wake_monitor_top.sv
module wake_monitor_top #(
    parameter int NCH        = 5,
    parameter int FILT_W     = 4,
    parameter int SETTLE_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NCH-1:0]    pin_in,
    input  logic [NCH-1:0]    chan_en,
    input  logic [1:0]        mode_sel,
    input  logic [FILT_W-1:0] filt_len,
    input  logic              stat_rd,
    output logic              wake_req,
    output logic [NCH-1:0]    stat_word
);
    logic [NCH-1:0] filt_lvl;
    logic [NCH-1:0] armed_mask;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        wkm_deglitch #(.LEN_W(FILT_W)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .raw   (pin_in[i]),
            .len   (filt_len),
            .lvl   (filt_lvl[i])
        );
        wkm_settle #(.DELAY(SETTLE_CYC)) u_stl (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (chan_en[i]),
            .armed (armed_mask[i])
        );
    end

    wkm_ctrl #(.NCH(NCH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .filt_lvl   (filt_lvl),
        .armed_mask (armed_mask),
        .chan_en    (chan_en),
        .stat_rd    (stat_rd),
        .wake_req   (wake_req),
        .stat_word  (stat_word)
    );
endmodule

// File: rtl/wkm_checker.sv
module wkm_checker #(
    parameter int NCH = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     mode_sel,
    input logic           stat_rd,
    input logic [NCH-1:0] chan_en,
    input logic [NCH-1:0] armed_mask,
    input logic           wake_req,
    input logic [NCH-1:0] stat_word
);
    assert_wake_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !stat_rd) |=> wake_req);

    assert_wake_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && stat_rd) |=> !wake_req);

    assert_wake_lowpwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(mode_sel[1]));

    assert_disabled_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_req |-> ((stat_word & ~chan_en) == '0));

    assert_src_armed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> ((stat_word & ~$past(armed_mask)) == '0));

    assert_src_present_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (stat_word != '0));
endmodule

bind wake_monitor_top wkm_checker #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .stat_rd    (stat_rd),
    .chan_en    (chan_en),
    .armed_mask (armed_mask),
    .wake_req   (wake_req),
    .stat_word  (stat_word)
);

// File: tb/sim_wake_monitor_top.sv
module sim_wake_monitor_top;
    localparam int NCH = 5;
    localparam int FW  = 4;
    localparam int SC  = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick = 1'b0;
    logic [NCH-1:0] pin_in = '0;
    logic [NCH-1:0] chan_en = '0;
    logic [1:0]     mode_sel = 2'b00;
    logic [FW-1:0]  filt_len = 4'd1;
    logic           stat_rd = 1'b0;
    logic           wake_req;
    logic [NCH-1:0] stat_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    wake_monitor_top #(.NCH(NCH), .FILT_W(FW), .SETTLE_CYC(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in),
        .chan_en(chan_en), .mode_sel(mode_sel), .filt_len(filt_len),
        .stat_rd(stat_rd), .wake_req(wake_req), .stat_word(stat_word)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic restart(input logic [NCH-1:0] en);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = 2'b00; pin_in = '0; chan_en = en;
        filt_len = 4'd1; tick = 1'b0; stat_rd = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
        wait_n(SC + 3);
    endtask

    task automatic t_reset();
        restart('1);
        chk("R1 wake_req after reset", wake_req, 0);
        chk("R1 stat_word after reset", stat_word, 0);
    endtask

    task automatic t_levels();
        restart('1);
        pin_in = 5'b10110; pulse_tick(); wait_n(2);
        chk("R2 active levels", stat_word, 5'b10110);
        mode_sel = 2'b01; wait_n(2);
        chk("R2 standby levels", stat_word, 5'b10110);
        chan_en = 5'b01111; wait_n(2);
        chk("R3 disabled bit reads zero", stat_word, 5'b00110);
        pulse_read(); wait_n(1);
        chk("R2 read in standby keeps live", stat_word, 5'b00110);
    endtask

    task automatic t_filter();
        restart('1);
        filt_len = 4'd4;
        pin_in = 5'b00001;
        repeat (3) pulse_tick();
        pin_in = 5'b00000; pulse_tick(); wait_n(2);
        chk("R4 short pulse rejected", stat_word, 0);
        pin_in = 5'b00001;
        repeat (3) pulse_tick(); wait_n(1);
        chk("R4 not yet accepted", stat_word, 0);
        pulse_tick(); wait_n(1);
        chk("R4 accepted after len ticks", stat_word, 5'b00001);
        filt_len = 4'd0; pin_in = 5'b00011;
        pulse_tick(); wait_n(1);
        chk("R5 zero length acts as one", stat_word, 5'b00011);
    endtask

    task automatic t_wake_rise();
        restart('1);
        mode_sel = 2'b10; wait_n(3);
        chk("R6 no wake without edge", wake_req, 0);
        pin_in = 5'b00001; pulse_tick(); wait_n(3);
        chk("R6 rising edge wakes in sleep", wake_req, 1);
        chk("R8 first status shows source", stat_word, 5'b00001);
        mode_sel = 2'b01; pin_in = 5'b00000; pulse_tick(); wait_n(4);
        chk("R7 wake held until read", wake_req, 1);
        chk("R8 source held until read", stat_word, 5'b00001);
        pin_in = 5'b00100; pulse_tick(); wait_n(1);
        pulse_read(); wait_n(1);
        chk("R8 read clears wake", wake_req, 0);
        chk("R8 later status is live", stat_word, 5'b00100);
    endtask

    task automatic t_wake_fall();
        restart('1);
        pin_in = 5'b00100; pulse_tick(); wait_n(2);
        mode_sel = 2'b11; wait_n(4);
        chk("R9 high pin at entry no wake", wake_req, 0);
        pin_in = 5'b00000; pulse_tick(); wait_n(3);
        chk("R6 falling edge wakes in stop", wake_req, 1);
        chk("R8 falling source flag", stat_word, 5'b00100);
    endtask

    task automatic t_multi();
        restart('1);
        mode_sel = 2'b10; wait_n(2);
        pin_in = 5'b01010; pulse_tick(); wait_n(3);
        chk("R10 both sources flagged", stat_word, 5'b01010);
        chk("R10 wake raised", wake_req, 1);
    endtask

    task automatic t_disabled();
        restart(5'b11110);
        mode_sel = 2'b10; wait_n(2);
        pin_in = 5'b00001; pulse_tick(); wait_n(4);
        chk("R3 disabled channel no wake", wake_req, 0);
        chk("R3 disabled channel reads zero", stat_word, 0);
    endtask

    task automatic t_settle();
        restart(5'b01111);
        mode_sel = 2'b10; wait_n(2);
        chan_en = 5'b11111; wait_n(2);
        pin_in = 5'b10000; pulse_tick(); wait_n(SC + 6);
        chk("R11 change during settle ignored", wake_req, 0);
        pin_in = 5'b00000; pulse_tick(); wait_n(3);
        chk("R11 armed channel wakes", wake_req, 1);
        chk("R11 source after settle", stat_word, 5'b10000);
    endtask

    task automatic t_exit();
        restart('1);
        pin_in = 5'b00010; pulse_tick(); wait_n(2);
        chk("R6 active change no wake", wake_req, 0);
        mode_sel = 2'b10; wait_n(3);
        mode_sel = 2'b01; wait_n(3);
        chk("R12 exit without event", wake_req, 0);
        chk("R12 first read is live", stat_word, 5'b00010);
    endtask

    initial begin
        t_reset();
        t_levels();
        t_filter();
        t_wake_rise();
        t_wake_fall();
        t_multi();
        t_disabled();
        t_settle();
        t_exit();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule